// File: doc/BRIEF.md
# Palette Colour Lookup Controller

This block keeps a colour lookup table of 256 entries. Each entry holds an 8-bit red, green and blue value. A host programs the table through a 16-byte register window on a simple 32-bit slave port. The host first writes an entry number to the index register. It then writes the three colour components, one after another, to the colour register. In both registers only the most significant byte of the bus word is used.

A small three-phase sequencer decides which component each colour write lands in. Its states are `PH_RED`, `PH_GREEN` and `PH_BLUE`, and its transitions are these:
- An index write moves any state to `PH_RED` and loads the index.
- A colour write in `PH_RED` goes to `PH_GREEN`.
- A colour write in `PH_GREEN` goes to `PH_BLUE`.
- A colour write in `PH_BLUE` goes back to `PH_RED` and advances the index by one, wrapping from 255 to 0.
- An unused phase encoding is handled exactly like `PH_RED`.

All other bus cycles leave the state as it is. Reads of the window always return zero.

A combinational lookup port turns an 8-bit pixel index into the 24-bit colour {R,G,B} stored for that entry. The display pipeline uses this port.

Top module: `palette_dac`

## Requirements
- R1: After reset, entries 0 to 254 read as 24'h000000 and entry 255 reads as 24'hFFFFFF. The index and the sequencer also start at zero, so the first colour write after reset stores the red component of entry 0.
- R2: A write (bus_valid=1, bus_write=1) with bus_addr=4'h0 loads the index from bus_wdata[31:24] and puts the sequencer in `PH_RED`.
- R3: Successive writes to bus_addr=4'h4 store bus_wdata[31:24] into the red, then green, then blue component of the current entry. Bits 23:0 are ignored. The lookup port presents red in bits 23:16, green in bits 15:8 and blue in bits 7:0.
- R4: After the blue component is stored, the index increments by one modulo 256 and the sequencer returns to `PH_RED`.
- R5: A colour write changes only the component being written. The other two components of that entry, and all other entries, keep their values.
- R6: The following have no effect on the table, the index or the sequencer: writes to any address other than 4'h0 and 4'h4, read cycles (bus_write=0), and cycles with bus_valid=0.
- R7: bus_rdata is zero for every access, including reads of 4'h0 and 4'h4.
- R8: pix_color is a combinational function of pix_index. A colour write becomes visible on pix_color in the cycle after the clock edge that accepted it.
- R9: An index write in the middle of a sequence restarts it at `PH_RED`. Components already written to the entry keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_valid | input | 1 | Bus access in this cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 4 | Byte offset inside the window |
| bus_wdata | input | 32 | Write data; only bits 31:24 are used |
| bus_rdata | output | 32 | Read data, always zero |
| pix_index | input | 8 | Pixel index to look up |
| pix_color | output | 24 | {R,G,B} of the entry selected by pix_index |

## Verification
Index loads, component stores and the sequencer advance all take effect at the clock edge that accepts the write. Their effect is therefore due one cycle after the stimulus, and read data is due in the same cycle as the read. The bench drives inputs shortly after a rising edge. It updates its reference model at the accepting edge and compares the lookup output and the read data at every falling edge. Directed checks set pix_index after an edge and sample one time step later, so each result is checked only in the cycle where it is due.

// File: rtl/pal_pkg.sv
package pal_pkg;
    // Sequencer phase: which colour component the next data write fills.
    typedef enum logic [1:0] {
        PH_RED   = 2'd0,
        PH_GREEN = 2'd1,
        PH_BLUE  = 2'd2
    } phase_e;

    localparam int NUM_COMP = 3;
    // Bit numbers of the component write enables.
    localparam int WE_RED   = 2;
    localparam int WE_GREEN = 1;
    localparam int WE_BLUE  = 0;
endpackage

// File: rtl/pal_seq.sv
module pal_seq
    import pal_pkg::*;
#(
    parameter int IDX_W = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 idx_load,
    input  logic                 color_wr,
    input  logic [IDX_W-1:0]     new_idx,
    output logic [IDX_W-1:0]     cur_idx,
    output phase_e               phase,
    output logic [NUM_COMP-1:0]  comp_we
);
    phase_e            phase_n;
    logic [IDX_W-1:0]  idx_n;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            phase   <= PH_RED;
            cur_idx <= '0;
        end else begin
            phase   <= phase_n;
            cur_idx <= idx_n;
        end
    end

    // Transitions
    always_comb begin
        phase_n = phase;
        idx_n   = cur_idx;
        if (idx_load) begin
            phase_n = PH_RED;
            idx_n   = new_idx;
        end else if (color_wr) begin
            unique case (phase)
                PH_RED:   phase_n = PH_GREEN;
                PH_GREEN: phase_n = PH_BLUE;
                PH_BLUE: begin
                    phase_n = PH_RED;
                    idx_n   = cur_idx + 1'b1;
                end
                default:  phase_n = PH_GREEN;
            endcase
        end
    end

    // Outputs: one component write enable per data write
    always_comb begin
        comp_we = '0;
        if (color_wr && !idx_load) begin
            unique case (phase)
                PH_GREEN: comp_we[WE_GREEN] = 1'b1;
                PH_BLUE:  comp_we[WE_BLUE]  = 1'b1;
                default:  comp_we[WE_RED]   = 1'b1;
            endcase
        end
    end
endmodule

// File: rtl/pal_store.sv
module pal_store
    import pal_pkg::*;
#(
    parameter int IDX_W  = 8,
    parameter int COMP_W = 8
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [NUM_COMP-1:0]          we,
    input  logic [IDX_W-1:0]             waddr,
    input  logic [COMP_W-1:0]            wdata,
    input  logic [IDX_W-1:0]             rd_idx,
    output logic [NUM_COMP*COMP_W-1:0]   rd_color
);
    localparam int DEPTH = 1 << IDX_W;

    // One plane per component; plane c drives bits [c*COMP_W +: COMP_W].
    for (genvar c = 0; c < NUM_COMP; c++) begin : g_plane
        logic [COMP_W-1:0] mem [DEPTH];

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                for (int i = 0; i < DEPTH; i++)
                    mem[i] <= (i == DEPTH - 1) ? '1 : '0;
            end else if (we[c]) begin
                mem[waddr] <= wdata;
            end
        end

        assign rd_color[c*COMP_W +: COMP_W] = mem[rd_idx];
    end
endmodule

// File: rtl/palette_dac.sv
module palette_dac
    import pal_pkg::*;
#(
    parameter int IDX_W     = 8,
    parameter int COMP_W    = 8,
    parameter int ADDR_W    = 4,
    parameter int DATA_W    = 32,
    parameter int OFS_INDEX = 0,
    parameter int OFS_COLOR = 4
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        bus_valid,
    input  logic                        bus_write,
    input  logic [ADDR_W-1:0]           bus_addr,
    input  logic [DATA_W-1:0]           bus_wdata,
    output logic [DATA_W-1:0]           bus_rdata,
    input  logic [IDX_W-1:0]            pix_index,
    output logic [NUM_COMP*COMP_W-1:0]  pix_color
);
    localparam int IDX_LSB  = DATA_W - IDX_W;
    localparam int COMP_LSB = DATA_W - COMP_W;

    logic                 wr_hit;
    logic                 idx_load;
    logic                 color_wr;
    logic [IDX_W-1:0]     seq_idx;
    phase_e               seq_phase;
    logic [NUM_COMP-1:0]  comp_we;

    assign wr_hit   = bus_valid && bus_write;
    assign idx_load = wr_hit && (bus_addr == ADDR_W'(OFS_INDEX));
    assign color_wr = wr_hit && (bus_addr == ADDR_W'(OFS_COLOR));
    assign bus_rdata = '0;

    pal_seq #(.IDX_W(IDX_W)) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .idx_load (idx_load),
        .color_wr (color_wr),
        .new_idx  (bus_wdata[IDX_LSB +: IDX_W]),
        .cur_idx  (seq_idx),
        .phase    (seq_phase),
        .comp_we  (comp_we)
    );

    pal_store #(.IDX_W(IDX_W), .COMP_W(COMP_W)) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .we       (comp_we),
        .waddr    (seq_idx),
        .wdata    (bus_wdata[COMP_LSB +: COMP_W]),
        .rd_idx   (pix_index),
        .rd_color (pix_color)
    );
endmodule

// File: rtl/palette_dac_chk.sv
module palette_dac_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        bus_valid,
    input logic        bus_write,
    input logic [3:0]  bus_addr,
    input logic [31:0] bus_wdata,
    input logic [7:0]  pix_index,
    input logic [23:0] pix_color,
    input logic [1:0]  phase,
    input logic [7:0]  cur_idx,
    input logic [2:0]  comp_we
);
    logic wr_index, wr_color, no_effect;
    assign wr_index  = bus_valid && bus_write && bus_addr == 4'h0;
    assign wr_color  = bus_valid && bus_write && bus_addr == 4'h4;
    assign no_effect = !(wr_index || wr_color);

    assert_idx_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_index |=> (cur_idx == $past(bus_wdata[31:24]) && phase == 2'd0));

    assert_red_to_green_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_color && phase == 2'd0) |=> phase == 2'd1);

    assert_wrap_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_color && phase == 2'd2) |=> (cur_idx == 8'($past(cur_idx) + 8'd1) && phase == 2'd0));

    assert_single_comp_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(comp_we));

    assert_ignored_R6: assert property (@(posedge clk) disable iff (!rst_n)
        no_effect |=> ($stable(cur_idx) && $stable(phase)));

    assert_lookup_next_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_color && phase == 2'd0 && pix_index == cur_idx) |=>
        (!$stable(pix_index) || pix_color[23:16] == $past(bus_wdata[31:24])));
endmodule

bind palette_dac palette_dac_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_valid (bus_valid),
    .bus_write (bus_write),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .pix_index (pix_index),
    .pix_color (pix_color),
    .phase     (seq_phase),
    .cur_idx   (seq_idx),
    .comp_we   (comp_we)
);

// File: tb/palette_dac_test.sv
`timescale 1ns/1ps
module palette_dac_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_valid = 1'b0;
    logic        bus_write = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [7:0]  pix_index = '0;
    logic [23:0] pix_color;

    int checks = 0;
    int errors = 0;
    bit cmp_en = 1'b0;

    // Reference model
    logic [7:0] mr [256];
    logic [7:0] mg [256];
    logic [7:0] mb [256];
    int m_idx = 0;
    int m_ph  = 0;

    always #5 clk = ~clk;

    palette_dac uut (
        .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pix_index(pix_index), .pix_color(pix_color)
    );

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 256; i++) begin
                mr[i] = (i == 255) ? 8'hFF : 8'h00;
                mg[i] = (i == 255) ? 8'hFF : 8'h00;
                mb[i] = (i == 255) ? 8'hFF : 8'h00;
            end
            m_idx = 0;
            m_ph  = 0;
        end else if (bus_valid && bus_write) begin
            if (bus_addr == 4'h0) begin
                m_idx = int'(bus_wdata[31:24]);
                m_ph  = 0;
            end else if (bus_addr == 4'h4) begin
                if (m_ph == 0) begin
                    mr[m_idx] = bus_wdata[31:24]; m_ph = 1;
                end else if (m_ph == 1) begin
                    mg[m_idx] = bus_wdata[31:24]; m_ph = 2;
                end else begin
                    mb[m_idx] = bus_wdata[31:24]; m_ph = 0;
                    m_idx = (m_idx + 1) % 256;
                end
            end
        end
    end

    // Per-cycle comparison against the model (R8, R7)
    always @(negedge clk) begin
        if (cmp_en) begin
            checks++;
            if (pix_color !== {mr[pix_index], mg[pix_index], mb[pix_index]}) begin
                errors++;
                $display("FAIL R8 model idx=%0d got %h expected %h", pix_index, pix_color,
                         {mr[pix_index], mg[pix_index], mb[pix_index]});
            end
            checks++;
            if (bus_rdata !== 32'h0) begin
                errors++;
                $display("FAIL R7 rdata got %h expected 00000000", bus_rdata);
            end
        end
    end

    task automatic chk_entry(input logic [7:0] idx, input logic [23:0] exp, input string tag);
        pix_index = idx;
        #1;
        checks++;
        if (pix_color !== exp) begin
            errors++;
            $display("FAIL %s entry %0d got %h expected %h", tag, idx, pix_color, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(posedge clk); #1;
        bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk); #1;
        bus_valid = 1'b0; bus_write = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a);
        @(posedge clk); #1;
        bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a; bus_wdata = 32'hDEADBEEF;
        #1;
        checks++;
        if (bus_rdata !== 32'h0) begin
            errors++;
            $display("FAIL R7 read addr %h got %h expected 00000000", a, bus_rdata);
        end
        @(posedge clk); #1;
        bus_valid = 1'b0;
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL R8 watchdog got timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        // R1: reset contents, one entry per cycle
        for (int i = 0; i < 256; i++) begin
            @(posedge clk); #1;
            chk_entry(8'(i), (i == 255) ? 24'hFFFFFF : 24'h000000, "R1");
        end
        cmp_en = 1'b1;
        // R1: index and phase start at zero
        wr(4'h4, 32'h11000000);
        chk_entry(8'd0, 24'h110000, "R1");
        // R2, R3, R5: index load then three components
        wr(4'h0, 32'h05ABCDEF);
        wr(4'h4, 32'hAA000000);
        chk_entry(8'd5, 24'hAA0000, "R5");
        wr(4'h4, 32'hBB000000);
        chk_entry(8'd5, 24'hAABB00, "R5");
        wr(4'h4, 32'hCC000000);
        chk_entry(8'd5, 24'hAABBCC, "R3");
        chk_entry(8'd4, 24'h000000, "R5");
        // R4: index advanced to 6; R3: low bits ignored
        wr(4'h4, 32'h7F123456);
        chk_entry(8'd6, 24'h7F0000, "R4");
        chk_entry(8'd5, 24'hAABBCC, "R5");
        // R4: wrap from 255 to 0
        wr(4'h0, 32'hFF000000);
        wr(4'h4, 32'h10000000);
        wr(4'h4, 32'h20000000);
        wr(4'h4, 32'h30000000);
        chk_entry(8'd255, 24'h102030, "R3");
        wr(4'h4, 32'h44000000);
        chk_entry(8'd0, 24'h440000, "R4");
        // R6: ignored accesses
        wr(4'h8, 32'hEE000000);
        wr(4'hC, 32'hEE000000);
        wr(4'h1, 32'hEE000000);
        rd(4'h4);
        rd(4'h0);
        @(posedge clk); #1;
        bus_valid = 1'b0; bus_write = 1'b1; bus_addr = 4'h4; bus_wdata = 32'hEE000000;
        @(posedge clk); #1;
        bus_write = 1'b0;
        chk_entry(8'd0, 24'h440000, "R6");
        wr(4'h4, 32'h55000000);
        chk_entry(8'd0, 24'h445500, "R6");
        // R9: index write mid-sequence restarts at red
        wr(4'h0, 32'h10000000);
        wr(4'h4, 32'h21000000);
        wr(4'h4, 32'h22000000);
        wr(4'h0, 32'h10000000);
        wr(4'h4, 32'h31000000);
        chk_entry(8'd16, 24'h312200, "R9");
        // R8: lookup changes in the cycle after the write edge
        pix_index = 8'h20;
        wr(4'h0, 32'h20000000);
        chk_entry(8'h20, 24'h000000, "R8");
        wr(4'h4, 32'h99000000);
        chk_entry(8'h20, 24'h990000, "R8");
        repeat (4) @(posedge clk);
        #1 cmp_en = 1'b0;
        finish_run();
    end
endmodule